// File: doc/BRIEF.md
# Dead-Time Complementary Output Generator

This block turns a single PWM reference into the two gate commands of an inverter half-bridge: a high-side drive that follows the reference and a low-side drive that follows its inverse. Each drive is switched on only after a programmable delay, measured from the clock edge that first samples the reference level calling for it. Each drive is switched off at the first clock edge that samples the opposite level. The two switches are therefore never commanded on together, and each turn-on is preceded by a gap of the programmed length.

The delay comes from an 8-bit code. Its top bits pick one of four ranges, each with its own step size and base offset, so short dead times get fine resolution and long ones stay reachable with 8 bits. At a 170 MHz clock the code 149 gives 170 cycles, which is 1 µs.

An emergency break input forces both drives inactive at once, without waiting for a clock edge. The break is latched. Drive resumes only after the break has been released and the output enable has been taken low and then high again. A low output enable also parks both drives inactive.

Top module: `dtg_pair_top`

## Requirements
- R1: For a code with bit 7 = 0, the delay D in clock cycles equals code[6:0] (0 to 127).
- R2: For a code with bits 7:6 = 10, D = (64 + code[5:0]) × 2 (128 to 254). Code 149 gives D = 170.
- R3: For a code with bits 7:5 = 110, D = (32 + code[4:0]) × 8 (256 to 504).
- R4: For a code with bits 7:5 = 111, D = (32 + code[4:0]) × 16 (512 to 1008).
- R5: If pwm_ref is held high, oc_hi goes high after the (D+1)th rising clock edge that samples pwm_ref high. If pwm_ref is held low, oc_lo goes high after the (D+1)th edge that samples it low.
- R6: oc_hi goes low after the first edge that samples pwm_ref low, and oc_lo goes low after the first edge that samples it high. oc_hi and oc_lo are never both high.
- R7: A reference pulse that is sampled high on D or fewer consecutive edges leaves oc_hi low throughout. A pulse sampled on D+1 edges gives a one-cycle oc_hi pulse.
- R8: While brk is high, oc_hi and oc_lo are both low. This holds from the moment brk rises, with no clock edge needed.
- R9: Once brk has been sampled high, both outputs stay low after brk drops. They return only after an edge samples out_en high while the previous edge sampled it low, with brk low at both edges.
- R10: During reset both outputs are low. One edge after out_en is sampled low, both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dead-time clock; every delay is counted in its periods |
| rst_n | input | 1 | Synchronous active-low reset |
| pwm_ref | input | 1 | PWM reference; high calls for the high-side switch |
| dt_code | input | 8 | Dead-time code (range and step per R1–R4) |
| brk | input | 1 | Emergency break; forces both outputs low at once, latched |
| out_en | input | 1 | Output enable; a low-to-high step re-arms the outputs |
| oc_hi | output | 1 | High-side gate command |
| oc_lo | output | 1 | Low-side gate command, complementary to oc_hi |

## Verification
A turn-on is due D+1 rising edges after the edge that first samples the new reference level, so the bench changes inputs on falling edges and counts rising edges until the drive appears on a falling-edge sample. That count is compared with D+1 for each code in a table that spans every range boundary. Turn-off and a fall of out_en are each due one edge after they are sampled, and re-arming takes one edge after out_en is sampled high again. The bench samples on the next falling edge in each case. The break acts without a clock, so it is checked one time unit after brk changes, before any edge.

// File: rtl/dtg_pkg.sv
`timescale 1ns/1ps
// Package: shared widths and the range encoding of the dead-time code.
// Assumes an 8-bit code; the counter width covers the largest delay (1008).
package dtg_pkg;
    localparam int DTG_CODE_W = 8;
    localparam int DTG_CNT_W  = 10;
    localparam int DTG_LEGS   = 2;

    typedef logic [DTG_CNT_W-1:0] dtg_dly_t;

    typedef enum logic [1:0] {
        DT_RNG_FINE = 2'd0,
        DT_RNG_X2   = 2'd1,
        DT_RNG_X8   = 2'd2,
        DT_RNG_X16  = 2'd3
    } dtg_range_e;
endpackage

// File: rtl/dtg_code_decode.sv
`timescale 1ns/1ps
// Module: dtg_code_decode
// Maps the 8-bit dead-time code to a delay in clock cycles. The top bits
// pick the range; each range adds its own base offset and scales by a
// power of two. Purely combinational; assumes the code is stable or that
// a change mid-delay is tolerable (legs compare with >=).
module dtg_code_decode
    import dtg_pkg::*;
#(
    parameter int CODE_W = DTG_CODE_W,
    parameter int CNT_W  = DTG_CNT_W
) (
    input  logic [CODE_W-1:0] code_i,
    output logic [CNT_W-1:0]  dly_o
);
    dtg_range_e rng;

    // Pick the range from the leading bits of the code.
    always_comb begin
        if (!code_i[7])      rng = DT_RNG_FINE;
        else if (!code_i[6]) rng = DT_RNG_X2;
        else if (!code_i[5]) rng = DT_RNG_X8;
        else                 rng = DT_RNG_X16;
    end

    // Form base-plus-field and apply the range scale as a shift.
    always_comb begin
        unique case (rng)
            DT_RNG_FINE: dly_o = CNT_W'({3'b000, code_i[6:0]});
            DT_RNG_X2:   dly_o = CNT_W'({2'b00, 1'b1, code_i[5:0], 1'b0});
            DT_RNG_X8:   dly_o = CNT_W'({1'b0, 1'b1, code_i[4:0], 3'b000});
            default:     dly_o = CNT_W'({1'b1, code_i[4:0], 4'b0000});
        endcase
    end
endmodule

// File: rtl/dtg_leg_delay.sv
`timescale 1ns/1ps
// Module: dtg_leg_delay
// Delays the rising edge of one leg's demand by dly_i cycles and drops
// the drive at the first edge that samples the demand low. A demand
// shorter than the delay never reaches the drive. Assumes the demand is
// synchronous to clk.
module dtg_leg_delay
    import dtg_pkg::*;
#(
    parameter int CNT_W = DTG_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             level_i,
    input  logic [CNT_W-1:0] dly_i,
    output logic             drive_o
);
    logic [CNT_W-1:0] cnt_q;
    logic             drive_q;

    // Count cycles of demand; arm the drive once the count reaches the delay.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            drive_q <= 1'b0;
        end else if (!level_i) begin
            cnt_q   <= '0;
            drive_q <= 1'b0;
        end else if (cnt_q >= dly_i) begin
            drive_q <= 1'b1;
        end else begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    assign drive_o = drive_q;
endmodule

// File: rtl/dtg_break_gate.sv
`timescale 1ns/1ps
// Module: dtg_break_gate
// Gates both leg drives. brk kills the outputs combinationally and clears
// the run flag; run is set again only by an out_en low-to-high step seen
// with brk low. Assumes brk may be asynchronous; only its sampled value
// affects state.
module dtg_break_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic brk_i,
    input  logic en_i,
    input  logic hi_i,
    input  logic lo_i,
    output logic hi_o,
    output logic lo_o
);
    logic en_q;
    logic run_q;

    // Remember the previous output enable to find its rising step.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= en_i;
    end

    // Run flag: cleared by break or disable, set by a fresh enable.
    always_ff @(posedge clk) begin
        if (!rst_n)               run_q <= 1'b0;
        else if (brk_i || !en_i)  run_q <= 1'b0;
        else if (!en_q)           run_q <= 1'b1;
    end

    assign hi_o = hi_i & run_q & ~brk_i;
    assign lo_o = lo_i & run_q & ~brk_i;
endmodule

// File: rtl/dtg_pair_top.sv
`timescale 1ns/1ps
// Module: dtg_pair_top
// Complementary dead-time generator for one half-bridge. The decoded code
// feeds two identical delay legs (reference and its inverse); the break
// gate then applies break and enable. Assumes pwm_ref, dt_code and out_en
// are synchronous to clk.
module dtg_pair_top
    import dtg_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pwm_ref,
    input  logic [DTG_CODE_W-1:0] dt_code,
    input  logic                  brk,
    input  logic                  out_en,
    output logic                  oc_hi,
    output logic                  oc_lo
);
    dtg_dly_t             dly;
    logic [DTG_LEGS-1:0]  leg_level;
    logic [DTG_LEGS-1:0]  leg_drive;

    dtg_code_decode #(.CODE_W(DTG_CODE_W), .CNT_W(DTG_CNT_W)) u_dec (
        .code_i (dt_code),
        .dly_o  (dly)
    );

    // Leg 0 follows the reference, leg 1 its complement.
    assign leg_level = {~pwm_ref, pwm_ref};

    for (genvar g = 0; g < DTG_LEGS; g++) begin : g_leg
        dtg_leg_delay #(.CNT_W(DTG_CNT_W)) u_leg (
            .clk     (clk),
            .rst_n   (rst_n),
            .level_i (leg_level[g]),
            .dly_i   (dly),
            .drive_o (leg_drive[g])
        );
    end

    dtg_break_gate u_gate (
        .clk   (clk),
        .rst_n (rst_n),
        .brk_i (brk),
        .en_i  (out_en),
        .hi_i  (leg_drive[0]),
        .lo_i  (leg_drive[1]),
        .hi_o  (oc_hi),
        .lo_o  (oc_lo)
    );
endmodule

// File: rtl/dtg_pair_chk.sv
`timescale 1ns/1ps
// Module: dtg_pair_chk
// Port-level properties of the dead-time generator, bound to the top.
module dtg_pair_chk (
    input logic clk,
    input logic rst_n,
    input logic pwm_ref,
    input logic brk,
    input logic out_en,
    input logic oc_hi,
    input logic oc_lo
);
    AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        !(oc_hi && oc_lo)); // R6
    AST_HI_OFF_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        !pwm_ref |=> !oc_hi); // R6
    AST_LO_OFF_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_ref |=> !oc_lo); // R6
    AST_BRK_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        brk |-> (!oc_hi && !oc_lo)); // R8
    AST_BRK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(brk) && $past(out_en)) |-> (!oc_hi && !oc_lo)); // R9
    AST_DISABLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |=> (!oc_hi && !oc_lo)); // R10
    AST_HI_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oc_hi) |-> $past(pwm_ref)); // R5
    AST_LO_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oc_lo) |-> !$past(pwm_ref)); // R5
endmodule

bind dtg_pair_top dtg_pair_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .pwm_ref (pwm_ref),
    .brk     (brk),
    .out_en  (out_en),
    .oc_hi   (oc_hi),
    .oc_lo   (oc_lo)
);

// File: tb/sim_dtg_pair_top.sv
`timescale 1ns/1ps
module sim_dtg_pair_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 11;
    localparam int WDOG_CYC   = 150000;

    // {code, expected delay}
    localparam logic [17:0] VEC [0:NVEC-1] = '{
        {8'd0,   10'd0},   {8'd1,   10'd1},   {8'd74,  10'd74},
        {8'd127, 10'd127}, {8'd128, 10'd128}, {8'd149, 10'd170},
        {8'd191, 10'd254}, {8'd192, 10'd256}, {8'd223, 10'd504},
        {8'd224, 10'd512}, {8'd255, 10'd1008}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwm_ref = 1'b0;
    logic [7:0] dt_code = 8'd0;
    logic       brk = 1'b0;
    logic       out_en = 1'b0;
    logic       oc_hi;
    logic       oc_lo;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;
    bit  overlap = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dtg_pair_top u0 (
        .clk(clk), .rst_n(rst_n), .pwm_ref(pwm_ref), .dt_code(dt_code),
        .brk(brk), .out_en(out_en), .oc_hi(oc_hi), .oc_lo(oc_lo)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic string req_of(input logic [7:0] c);
        if (!c[7])      return "R1";
        else if (!c[6]) return "R2";
        else if (!c[5]) return "R3";
        else            return "R4";
    endfunction

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    // From a falling edge: drive pwm_ref, count edges until the leg turns on.
    task automatic measure_on(input bit hi_leg, output int n, output bit other_off);
        pwm_ref = hi_leg;
        n = 0;
        other_off = 1'b0;
        for (int i = 0; i < 1100; i++) begin
            cyc();
            n++;
            if (oc_hi && oc_lo) overlap = 1'b1;
            if (i == 0) other_off = hi_leg ? !oc_lo : !oc_hi;
            if (hi_leg ? oc_hi : oc_lo) break;
        end
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (WDOG_CYC) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
            finish_up();
        end
    end

    initial begin
        int  n;
        bit  off;
        bit  seen;
        out_en = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset state
        check(!oc_hi && !oc_lo, "R10", {oc_hi, oc_lo}, 0);
        rst_n = 1'b1;
        repeat (3) cyc();

        // Table: per code, high-leg and low-leg turn-on delay
        for (int v = 0; v < NVEC; v++) begin
            dt_code = VEC[v][17:10];
            measure_on(1'b1, n, off);
            check(n == int'(VEC[v][9:0]) + 1, req_of(dt_code), n, int'(VEC[v][9:0]) + 1);
            check(off, "R6", !off, 0);
            measure_on(1'b0, n, off);
            check(n == int'(VEC[v][9:0]) + 1, "R5", n, int'(VEC[v][9:0]) + 1);
            check(off, "R6", !off, 0);
        end
        check(!overlap, "R6", overlap, 0);

        // R7: pulse sampled on D edges is swallowed, D+1 gives a one-cycle pulse
        dt_code = 8'd10;
        repeat (2) cyc();
        seen = 1'b0;
        pwm_ref = 1'b1;
        for (int i = 0; i < 10; i++) begin cyc(); seen |= oc_hi; end
        pwm_ref = 1'b0;
        cyc(); seen |= oc_hi;
        check(!seen, "R7", seen, 0);
        repeat (2) cyc();
        seen = 1'b0;
        n = 0;
        pwm_ref = 1'b1;
        for (int i = 0; i < 11; i++) begin cyc(); seen |= oc_hi; n += oc_hi; end
        pwm_ref = 1'b0;
        cyc(); seen |= oc_hi; n += oc_hi;
        check(n == 1, "R7", n, 1);

        // R8/R9: break with the high leg driving
        dt_code = 8'd0;
        pwm_ref = 1'b1;
        repeat (3) cyc();
        check(oc_hi, "R5", oc_hi, 1);
        brk = 1'b1;
        #1;
        check(!oc_hi && !oc_lo, "R8", {oc_hi, oc_lo}, 0);
        @(negedge clk);
        brk = 1'b0;
        repeat (3) cyc();
        check(!oc_hi, "R9", oc_hi, 0);
        out_en = 1'b0;
        cyc();
        out_en = 1'b1;
        cyc();
        check(oc_hi, "R9", oc_hi, 1);

        // R8 on the low leg
        pwm_ref = 1'b0;
        repeat (3) cyc();
        check(oc_lo, "R5", oc_lo, 1);
        brk = 1'b1;
        #1;
        check(!oc_lo, "R8", oc_lo, 0);
        @(negedge clk);
        brk = 1'b0;
        out_en = 1'b0;
        cyc();
        out_en = 1'b1;
        cyc();
        check(oc_lo, "R9", oc_lo, 1);

        // R10: disable parks the outputs one edge later
        out_en = 1'b0;
        cyc();
        check(!oc_hi && !oc_lo, "R10", {oc_hi, oc_lo}, 0);
        out_en = 1'b1;
        cyc();
        check(oc_lo, "R10", oc_lo, 1);

        done = 1'b1;
        finish_up();
    end
endmodule